// File: doc/BRIEF.md
# Multi-Block Serial Bit Store

This block collects code blocks that arrive one bit per clock and keeps several of them resident at once in a circular bit memory. A block opens with a start strobe that carries the block length, and its bits are then taken at consecutive memory addresses whenever the new-data qualifier is high. The descriptor of a block, made of its base address and its length, goes into a descriptor FIFO only after the block's last bit has been written. A reader downstream therefore sees only complete blocks, in arrival order.

The reader works on the oldest descriptor. It pops the descriptor, which moves that block into a single "held" slot. It then fetches the block's bits through a read port with one cycle of latency. When it is done it releases the block, and the block's bits become free space again. Input stalls in two cases: when one more bit would overwrite a block that has not been released, and when the descriptor FIFO is full. Apart from those stalls, blocks can follow one another with no idle cycle between them.

Top module: `blk_bit_store`

## Requirements
- R1: After reset, and after a synchronous clear sampled with clock enable high, the block is idle: rfd=1, rffd=1, len_empty=1, len_full=0. The write address restarts at 0 and no stored block or held block remains.
- R2: A block start is taken only on an edge where rffd, fd and nd are all high. On that edge din is stored as bit 0 of the block, at the current write address, and blk_len is captured. fd with nd low has no effect.
- R3: rffd falls on the edge that takes a start (for lengths above 1). It stays low while the block is being filled and is high again right after the edge that takes the block's last qualified bit.
- R4: While nd is low, din is ignored and the write address does not move.
- R5: rffd is never high while rfd is low.
- R6: Bits are written at consecutive addresses of a 2^ADDR_W-bit memory (16384 bits by default), wrapping modulo its size. Bit i of a block with base b is read back on rd_bit one cycle after rd_addr = (b+i) mod 16384.
- R7: A block's descriptor (head_base, head_len) enters the FIFO only after its last bit has been taken. The FIFO head always shows the oldest descriptor not yet popped, and len_pop removes it.
- R8: rfd is low whenever the bits that have been written but not released fill the whole memory. No bit is written while rfd is low, and rfd stays low after a pop until the held block is released.
- R9: rfd and rffd are low while the descriptor FIFO is full (FIFO_DEPTH entries, 32 by default), and a start presented then is ignored. One pop makes rfd high again.
- R10: While ce is low, every state element holds its value, and sclr, fd, nd and din are ignored.
- R11: A new block start can be taken on the cycle right after the last bit of the previous block, so back-to-back blocks stream with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable; low freezes all state |
| sclr | input | 1 | Synchronous clear, active high, qualified by ce |
| din | input | 1 | Serial data bit |
| nd | input | 1 | New-data qualifier for din and fd |
| fd | input | 1 | First-bit strobe that opens a block |
| blk_len | input | 13 | Block length in bits, sampled with a taken start |
| rfd | output | 1 | Ready to take a data bit |
| rffd | output | 1 | Ready to take a block start |
| len_pop | input | 1 | Pop the oldest descriptor into the held slot |
| blk_release | input | 1 | Free the held block's bits |
| head_len | output | 13 | Length of the oldest complete block |
| head_base | output | 14 | Base bit address of the oldest complete block |
| len_empty | output | 1 | Descriptor FIFO empty |
| len_full | output | 1 | Descriptor FIFO full |
| rd_addr | input | 14 | Read bit address |
| rd_bit | output | 1 | Bit at rd_addr, one cycle later |

## Verification
The bound checker watches four things on every cycle: the write address holds while nd is low, no write happens while the memory is full, a full FIFO stays full unless it is popped, and the whole state freezes while ce is low. It also checks that a clear forces the idle state and that a taken start drops rffd. Some behaviours are only visible through the bench's scenarios: bit-exact contents and base addresses, including a block that wraps past address 16383; the exact bit count at which memory exhaustion stalls input; the release that lifts that stall; the gap-free back-to-back start; and a start attempted while the FIFO is full, which must be ignored.

// File: rtl/blk_buf_pkg.sv
// Package: shared defaults and the write-side state type of the bit store.
// Assumes: the memory depth is a power of two and holds two 6144-bit blocks.
package blk_buf_pkg;
    localparam int unsigned DEF_ADDR_W     = 14;
    localparam int unsigned DEF_LEN_W      = 13;
    localparam int unsigned DEF_FIFO_DEPTH = 32;
    localparam int unsigned DEF_WORD_W     = 32;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_FILL = 1'b1
    } wr_state_e;
endpackage

// File: rtl/blk_wr_ctrl.sv
// Module: write-side sequencer. It takes block starts and qualified bits,
// produces the memory write strobe and address, and emits a descriptor
// (base, length) on the edge that takes a block's last bit.
// Assumes: the caller gates ce/sclr; the memory-full and FIFO-full flags are registered.
module blk_wr_ctrl
    import blk_buf_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned LEN_W  = DEF_LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              sclr,
    input  logic              nd,
    input  logic              fd,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic              mem_full,
    input  logic              fifo_full,
    output logic              rfd,
    output logic              rffd,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              push,
    output logic [ADDR_W-1:0] push_base,
    output logic [LEN_W-1:0]  push_len
);
    wr_state_e         st_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  remain_q;
    logic              is_last;

    // Handshakes, the take decision and the descriptor for the block being closed.
    always_comb begin
        rfd       = !mem_full && !fifo_full;
        rffd      = rfd && (st_q == WR_IDLE);
        wr_en     = ce && !sclr && rfd && nd && ((st_q == WR_FILL) || fd);
        is_last   = (st_q == WR_IDLE) ? (blk_len == LEN_W'(1)) : (remain_q == LEN_W'(1));
        push      = wr_en && is_last;
        push_base = (st_q == WR_IDLE) ? ptr_q : base_q;
        push_len  = (st_q == WR_IDLE) ? blk_len : len_q;
        wr_addr   = ptr_q;
    end

    // Sequence state: write pointer, current block base/length, bits still to take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= WR_IDLE;
            ptr_q    <= '0;
            base_q   <= '0;
            len_q    <= '0;
            remain_q <= '0;
        end else if (ce) begin
            if (sclr) begin
                st_q     <= WR_IDLE;
                ptr_q    <= '0;
                base_q   <= '0;
                len_q    <= '0;
                remain_q <= '0;
            end else if (wr_en) begin
                ptr_q <= ptr_q + 1'b1;
                if (st_q == WR_IDLE) begin
                    base_q   <= ptr_q;
                    len_q    <= blk_len;
                    remain_q <= blk_len - LEN_W'(1);
                    st_q     <= is_last ? WR_IDLE : WR_FILL;
                end else begin
                    remain_q <= remain_q - LEN_W'(1);
                    if (is_last) begin
                        st_q <= WR_IDLE;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/blk_len_fifo.sv
// Module: descriptor FIFO of {base, length} words for complete blocks.
// Assumes: DEPTH is a power of two; push and pop arrive already qualified
// (never a push when full or a pop when empty); clr is already gated by ce.
module blk_len_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned DW    = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [DW-1:0]    store [DEPTH];
    logic [PTR_W-1:0] wp_q;
    logic [PTR_W-1:0] rp_q;
    logic [PTR_W:0]   cnt_q;

    // Flags and the head word, taken straight from the registers.
    always_comb begin
        empty = (cnt_q == '0);
        full  = (cnt_q == (PTR_W+1)'(DEPTH));
        head  = store[rp_q];
    end

    // Storage write; the entries themselves need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wp_q] <= push_data;
        end
    end

    // Pointer and count upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        end
    end
endmodule

// File: rtl/blk_bit_ram.sv
// Module: circular 1-bit memory, packed as WORD_W-bit words, with one write
// port and a registered read port (one cycle of latency).
// Assumes: WORD_W is a power of two that divides 2**ADDR_W.
module blk_bit_ram #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rbit
);
    localparam int unsigned SEL_W = $clog2(WORD_W);
    localparam int unsigned WORDS = (1 << ADDR_W) / WORD_W;

    logic [WORD_W-1:0] mem [WORDS];

    // Single-bit write into the word selected by the upper address bits.
    always_ff @(posedge clk) begin
        if (ce && we) begin
            mem[waddr[ADDR_W-1:SEL_W]][waddr[SEL_W-1:0]] <= wbit;
        end
    end

    // Registered read, frozen while ce is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbit <= 1'b0;
        end else if (ce) begin
            rbit <= mem[raddr[ADDR_W-1:SEL_W]][raddr[SEL_W-1:0]];
        end
    end
endmodule

// File: rtl/blk_buf_occ.sv
// Module: occupancy tracker. It counts bits that have been written but not
// released and keeps the single held slot (the popped block awaiting release).
// Assumes: the reader releases the held block no later than the cycle it pops the next one.
module blk_buf_occ #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              sclr,
    input  logic              wr_en,
    input  logic              pop_q,
    input  logic [LEN_W-1:0]  head_len,
    input  logic              rel_req,
    output logic [ADDR_W:0]   used_bits,
    output logic              mem_full
);
    localparam logic [ADDR_W:0] FULL_CNT = {1'b1, {ADDR_W{1'b0}}};

    logic             held_v;
    logic [LEN_W-1:0] held_len;
    logic             rel_q;

    // Release is honoured only when a block is held.
    always_comb begin
        rel_q    = ce && !sclr && rel_req && held_v;
        mem_full = (used_bits == FULL_CNT);
    end

    // Held slot: a pop captures the head length, a release frees the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v   <= 1'b0;
            held_len <= '0;
        end else if (ce) begin
            if (sclr) begin
                held_v   <= 1'b0;
                held_len <= '0;
            end else if (pop_q) begin
                held_v   <= 1'b1;
                held_len <= head_len;
            end else if (rel_q) begin
                held_v <= 1'b0;
            end
        end
    end

    // Resident bit count: +1 per written bit, minus the held length on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_bits <= '0;
        end else if (ce) begin
            if (sclr) begin
                used_bits <= '0;
            end else begin
                used_bits <= used_bits + (ADDR_W+1)'(wr_en)
                             - (rel_q ? (ADDR_W+1)'(held_len) : '0);
            end
        end
    end
endmodule

// File: rtl/blk_bit_store.sv
// Module: top of the multi-block bit store. It connects the write sequencer,
// the bit memory, the descriptor FIFO and the occupancy tracker.
// Assumes: block lengths are 1..2**LEN_W-1 and fit the memory; the reader
// pops only when a descriptor is present and releases before its next pop.
module blk_bit_store
    import blk_buf_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LEN_W      = DEF_LEN_W,
    parameter int unsigned FIFO_DEPTH = DEF_FIFO_DEPTH,
    parameter int unsigned WORD_W     = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              sclr,
    input  logic              din,
    input  logic              nd,
    input  logic              fd,
    input  logic [LEN_W-1:0]  blk_len,
    output logic              rfd,
    output logic              rffd,
    input  logic              len_pop,
    input  logic              blk_release,
    output logic [LEN_W-1:0]  head_len,
    output logic [ADDR_W-1:0] head_base,
    output logic              len_empty,
    output logic              len_full,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    localparam int unsigned DESC_W = ADDR_W + LEN_W;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              push;
    logic [ADDR_W-1:0] push_base;
    logic [LEN_W-1:0]  push_len;
    logic              mem_full;
    logic [ADDR_W:0]   used_bits;
    logic              pop_q;
    logic              fifo_clr;
    logic [DESC_W-1:0] head_word;

    // Qualified pop and clear for the FIFO, and the split of the head word.
    always_comb begin
        pop_q     = ce && !sclr && len_pop && !len_empty;
        fifo_clr  = ce && sclr;
        head_base = head_word[DESC_W-1:LEN_W];
        head_len  = head_word[LEN_W-1:0];
    end

    blk_wr_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .nd(nd), .fd(fd),
        .blk_len(blk_len), .mem_full(mem_full), .fifo_full(len_full),
        .rfd(rfd), .rffd(rffd), .wr_en(wr_en), .wr_addr(wr_addr),
        .push(push), .push_base(push_base), .push_len(push_len)
    );

    blk_bit_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(wr_en), .waddr(wr_addr),
        .wbit(din), .raddr(rd_addr), .rbit(rd_bit)
    );

    blk_len_fifo #(.DEPTH(FIFO_DEPTH), .DW(DESC_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push),
        .push_data({push_base, push_len}), .pop(pop_q), .head(head_word),
        .empty(len_empty), .full(len_full)
    );

    blk_buf_occ #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_occ (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .wr_en(wr_en),
        .pop_q(pop_q), .head_len(head_len), .rel_req(blk_release),
        .used_bits(used_bits), .mem_full(mem_full)
    );
endmodule

// File: rtl/blk_bit_store_chk.sv
// Module: property checker for blk_bit_store, attached with bind below.
// Assumes: it sees the top's ports plus the write strobe, write address and resident count.
module blk_bit_store_chk #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned LEN_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              sclr,
    input logic              fd,
    input logic              nd,
    input logic [LEN_W-1:0]  blk_len,
    input logic              len_pop,
    input logic              rffd,
    input logic              len_full,
    input logic              len_empty,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W:0]   used_bits
);
    localparam logic [ADDR_W:0] FULL_CNT = {1'b1, {ADDR_W{1'b0}}};

    // R1
    clear_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && sclr) |=> (rffd && len_empty && used_bits == '0));

    // R3
    start_drops_rffd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !sclr && rffd && fd && nd && blk_len > LEN_W'(1)) |=> !rffd);

    // R4
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !sclr && !nd) |=> $stable(wr_addr));

    // R8
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (used_bits == FULL_CNT) |-> !wr_en);

    // R9
    fifo_hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !sclr && len_full && !len_pop) |=> len_full);

    // R10
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(wr_addr) && $stable(used_bits) && $stable(len_empty) && $stable(rffd)));
endmodule

bind blk_bit_store blk_bit_store_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .fd(fd), .nd(nd),
    .blk_len(blk_len), .len_pop(len_pop), .rffd(rffd), .len_full(len_full),
    .len_empty(len_empty), .wr_en(wr_en), .wr_addr(wr_addr), .used_bits(used_bits)
);

// File: tb/blk_bit_store_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected descriptor of each block
// it sends; the reader pops the queue and compares the head and every bit.
module blk_bit_store_bench;
    localparam int MEMB = 16384;

    typedef struct {
        int len;
        int base;
        int seed;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b1;
    logic        sclr = 1'b0;
    logic        din = 1'b0;
    logic        nd = 1'b0;
    logic        fd = 1'b0;
    logic [12:0] blk_len = '0;
    logic        rfd;
    logic        rffd;
    logic        len_pop = 1'b0;
    logic        blk_release = 1'b0;
    logic [12:0] head_len;
    logic [13:0] head_base;
    logic        len_empty;
    logic        len_full;
    logic [13:0] rd_addr = '0;
    logic        rd_bit;

    int   checks = 0;
    int   failures = 0;
    int   mdl_wptr = 0;
    int   acc_total = 0;
    int   r5_bad = 0;
    bit   stalled = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    blk_bit_store u_blk_bit_store (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .din(din), .nd(nd),
        .fd(fd), .blk_len(blk_len), .rfd(rfd), .rffd(rffd), .len_pop(len_pop),
        .blk_release(blk_release), .head_len(head_len), .head_base(head_base),
        .len_empty(len_empty), .len_full(len_full), .rd_addr(rd_addr), .rd_bit(rd_bit)
    );

    function automatic bit pat(input int seed, input int i);
        int h;
        h = i * 1103 + seed * 7919;
        h = h ^ (h >> 5) ^ (i >> 3);
        return h[2];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R5 monitor: rffd must never be high while rfd is low.
    always @(negedge clk) begin
        if (rst_n && rffd && !rfd) r5_bad++;
    end

    // Driver: sends one block; mode 1 inserts nd-low gaps, mode 2 inserts ce-low gaps.
    task automatic feed_block(input int len, input int seed, input int mode, output int waits);
        exp_t e;
        waits = 0;
        @(negedge clk);
        fd = 1'b0;
        nd = 1'b0;
        while (!rffd) begin
            waits++;
            @(negedge clk);
        end
        e.len = len; e.base = mdl_wptr; e.seed = seed;
        exp_q.push_back(e);
        fd = 1'b1; nd = 1'b1; din = pat(seed, 0); blk_len = 13'(len);
        mdl_wptr = (mdl_wptr + 1) % MEMB;
        acc_total++;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            fd = 1'b0;
            if (i == len / 2) begin
                chk(rffd == 1'b0, "R3 rffd mid-block", int'(rffd), 0);
                if (exp_q.size() == 1) chk(len_empty == 1'b1, "R7 no early push", int'(len_empty), 1);
            end
            if (mode == 1 && (i % 5) == 2) begin
                nd = 1'b0; din = !pat(seed, i);
                @(negedge clk);
            end
            if (mode == 2 && (i % 5) == 2) begin
                ce = 1'b0; nd = 1'b1; din = !pat(seed, i);
                @(negedge clk);
                ce = 1'b1;
            end
            while (!rfd) begin
                stalled = 1'b1;
                nd = 1'b0;
                @(negedge clk);
            end
            nd = 1'b1; din = pat(seed, i);
            mdl_wptr = (mdl_wptr + 1) % MEMB;
            acc_total++;
        end
        @(posedge clk);
    endtask

    // Monitor/reader: compares the head with the scoreboard, pops, reads every bit, releases.
    task automatic drain_one(input int pop_mode);
        exp_t e;
        int   bad;
        @(negedge clk);
        fd = 1'b0; nd = 1'b0;
        while (len_empty) @(negedge clk);
        e = exp_q.pop_front();
        chk(int'(head_len) == e.len, "R7 head length", int'(head_len), e.len);
        chk(int'(head_base) == e.base, "R6 head base", int'(head_base), e.base);
        len_pop = 1'b1;
        @(negedge clk);
        len_pop = 1'b0;
        if (pop_mode == 1) chk(rfd == 1'b0, "R8 still stalled after pop", int'(rfd), 0);
        if (pop_mode == 2) chk(rfd == 1'b1, "R9 pop reopens input", int'(rfd), 1);
        bad = 0;
        for (int i = 0; i < e.len; i++) begin
            rd_addr = 14'((e.base + i) % MEMB);
            @(negedge clk);
            if (rd_bit !== pat(e.seed, i)) bad++;
        end
        chk(bad == 0, "R6 block contents", bad, 0);
        blk_release = 1'b1;
        @(negedge clk);
        blk_release = 1'b0;
        if (pop_mode == 1) chk(rfd == 1'b1, "R8 release reopens input", int'(rfd), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rfd == 1'b1 && rffd == 1'b1, "R1 reset handshakes", int'({rfd, rffd}), 3);
        chk(len_empty == 1'b1 && len_full == 1'b0, "R1 reset fifo flags", int'({len_empty, len_full}), 2);

        // R2: fd without nd is not a start; data with no start is ignored
        fd = 1'b1; nd = 1'b0; blk_len = 13'd40;
        @(negedge clk);
        chk(rffd == 1'b1, "R2 fd without nd ignored", int'(rffd), 1);
        fd = 1'b0; nd = 1'b1; din = 1'b1;
        @(negedge clk);
        nd = 1'b0;

        // R11 back-to-back, R4 nd gaps, R10 ce gaps
        feed_block(40, 1, 0, w);
        feed_block(64, 2, 1, w);
        chk(w == 0, "R11 gap-free next start", w, 0);
        feed_block(48, 3, 2, w);
        chk(w == 0, "R11 gap-free next start", w, 0);
        @(negedge clk);
        chk(rffd == 1'b1, "R3 rffd back after last bit", int'(rffd), 1);
        chk(len_empty == 1'b0, "R7 push after completion", int'(len_empty), 0);
        drain_one(0);
        drain_one(0);
        drain_one(0);

        // R10: ce low freezes, sclr ignored
        feed_block(40, 4, 0, w);
        @(negedge clk);
        ce = 1'b0; sclr = 1'b1; fd = 1'b1; nd = 1'b1;
        repeat (2) @(negedge clk);
        chk(len_empty == 1'b0, "R10 clear ignored while ce low", int'(len_empty), 0);
        chk(rffd == 1'b1, "R10 start ignored while ce low", int'(rffd), 1);
        ce = 1'b1; sclr = 1'b0; fd = 1'b0; nd = 1'b0;
        drain_one(0);

        // R1: synchronous clear
        feed_block(40, 5, 0, w);
        @(negedge clk);
        sclr = 1'b1;
        @(negedge clk);
        sclr = 1'b0;
        chk(len_empty == 1'b1 && len_full == 1'b0, "R1 clear fifo flags", int'({len_empty, len_full}), 2);
        chk(rfd == 1'b1 && rffd == 1'b1, "R1 clear handshakes", int'({rfd, rffd}), 3);
        exp_q.delete();
        mdl_wptr = 0;
        feed_block(40, 6, 0, w);
        drain_one(0);

        // R9: descriptor FIFO full
        for (int k = 0; k < 32; k++) feed_block(40, 100 + k, 0, w);
        @(negedge clk);
        chk(len_full == 1'b1, "R9 fifo full", int'(len_full), 1);
        chk(rfd == 1'b0 && rffd == 1'b0, "R9 input stalled", int'({rfd, rffd}), 0);
        fd = 1'b1; nd = 1'b1; din = 1'b1; blk_len = 13'd40;
        @(negedge clk);
        fd = 1'b0; nd = 1'b0;
        chk(len_full == 1'b1, "R9 start ignored while full", int'(len_full), 1);
        drain_one(2);
        for (int k = 1; k < 32; k++) drain_one(0);
        feed_block(40, 7, 0, w);
        drain_one(0);

        // R8: memory exhaustion, wrap-around (R6)
        acc_total = 0;
        stalled = 1'b0;
        feed_block(6144, 11, 0, w);
        feed_block(6144, 12, 0, w);
        fork
            feed_block(6144, 13, 0, w);
            begin
                wait (stalled == 1'b1);
                @(negedge clk);
                chk(rfd == 1'b0, "R8 stall on full memory", int'(rfd), 0);
                chk(acc_total == MEMB, "R8 bits taken before stall", acc_total, MEMB);
                chk(rffd == 1'b0, "R5 rffd low with rfd", int'(rffd), 0);
                drain_one(1);
            end
        join
        drain_one(0);
        drain_one(0);

        chk(r5_bad == 0, "R5 rffd implies rfd", r5_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule